// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a clock generator against a bad frequency setting. Software arms it with an enable bit and a 5-bit time-out count, then requests a frequency change. The accepted change starts a countdown whose unit is one of two prescaler periods. If software does not disarm the watchdog before the count runs out, the block sets a sticky time-out flag. It also selects the recovery frequency and locks, so that later frequency-change requests are refused. When enabled, it also pulls the system reset line low for a short pulse.

A second reset source can pulse the same reset line after every accepted frequency change. Time is supplied as a base tick enable (`tick_en`), so the real-time clock source stays outside the block. The reset pad is open drain. The block drives only its pull-down enable: 1 pulls the pad low, and 0 releases it to high-Z.

Top module: `wd_recovery_lock`

## Requirements
- R1: After reset, `wd_status`, `wd_locked`, `recov_sel` and `rst_pull_low` are all 0.
- R2: While armed, the countdown does not start until a frequency change is accepted. With no change, no time-out ever occurs.
- R3: With `wd_long`=0, the time-out occurs exactly `wd_count`×SHORT_UNIT base ticks after the edge that accepts the change. `wd_status` reads 1 from that edge on.
- R4: With `wd_long`=1, the unit is LONG_UNIT base ticks, so the time-out comes `wd_count`×LONG_UNIT ticks after the change.
- R5: A `wd_count` of 0 means 32 units.
- R6: `wd_status` is sticky. A write strobe with data 1 clears it, and a write strobe with data 0 leaves it unchanged.
- R7: A time-out sets `wd_locked` and `recov_sel`. While locked, `freq_wr_grant` stays 0 for any request, and a refused request neither restarts the countdown nor pulses reset. Clearing the status flag does not unlock.
- R8: Driving `wd_arm` to 0 clears the lock and recovery select at the next edge. After that, change requests are granted again.
- R9: With `rst_on_expire_en`=1, `rst_pull_low` is 1 for RST_TICKS base ticks starting at the time-out edge. With it at 0, no pulse is produced.
- R10: With `rst_on_change_en`=1, every accepted change makes `rst_pull_low` 1 for RST_TICKS base ticks, starting at the accepting edge.
- R11: Dropping `wd_arm` during a countdown stops it and reloads it, so no time-out follows.
- R12: A change accepted during a countdown restarts the full count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base time tick enable |
| wd_arm | input | 1 | Watchdog enable; 0 stops, reloads and unlocks |
| wd_count | input | TIMER_W | Time-out in prescaler units (0 = 2^TIMER_W) |
| wd_long | input | 1 | Prescaler select: 0 short unit, 1 long unit |
| rst_on_expire_en | input | 1 | Pulse reset on time-out |
| rst_on_change_en | input | 1 | Pulse reset on each accepted frequency change |
| freq_change_req | input | 1 | Frequency-change write request |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data (1 clears) |
| freq_wr_grant | output | 1 | Request accepted (not locked) |
| wd_status | output | 1 | Sticky time-out flag |
| wd_locked | output | 1 | Recovery lock active |
| recov_sel | output | 1 | Recovery frequency selected |
| rst_pull_low | output | 1 | Open-drain reset pull-down enable (1 = pad low) |

## Verification
The bench builds the block with SHORT_UNIT=3, LONG_UNIT=5 and RST_TICKS=2, and holds the base tick high. Every time-out therefore falls a few dozen cycles after its change and can be sampled on its exact edge. This covers the full 32-unit range of a zero count, the edge-exact reset pulse width, and the difference between the two prescaler units. The default units of 150 and 2500 ticks (for a 1 ms tick) only change the counter widths.

// File: rtl/wdr_pkg.sv
// Shared types for the frequency-change watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdr_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_LOCK = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wd_prescaler.sv
// Divides the base tick into time-out units of one of two lengths.
// Assumes: both unit lengths are at least 1; clr holds the divider at zero.
module wd_prescaler #(
    parameter int SHORT_UNIT = 150,
    parameter int LONG_UNIT  = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_en,
    input  logic long_sel,
    output logic unit_tick
);
    localparam int UMAX = (SHORT_UNIT > LONG_UNIT) ? SHORT_UNIT : LONG_UNIT;
    localparam int PW   = $clog2(UMAX + 1);
    localparam logic [PW-1:0] S_LIM = PW'(SHORT_UNIT - 1);
    localparam logic [PW-1:0] L_LIM = PW'(LONG_UNIT - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    // Pick the terminal count for the selected unit.
    always_comb lim = long_sel ? L_LIM : S_LIM;

    // One unit tick when the divider sits at its terminal count.
    always_comb unit_tick = !clr && tick_en && (pre_q >= lim);

    // Divider register: cleared while idle, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pre_q <= '0;
        else if (tick_en)
            pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wd_downcount.sv
// Unit down-counter; flags expiry when the last unit elapses.
// Assumes: a load value of zero means 2^TIMER_W units; load wins over dec.
module wd_downcount #(
    parameter int TIMER_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_val,
    input  logic               dec,
    output logic               expire
);
    localparam int CW = TIMER_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << TIMER_W;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_full;

    // Map a zero count to the full range.
    always_comb load_full = (load_val == '0) ? FULL : {1'b0, load_val};

    // Expiry is the decrement that takes the count from one to zero.
    always_comb expire = dec && !load && (cnt_q == CW'(1));

    // Count register: reload on request, else step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_full;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/wd_rst_pulse.sv
// Stretches a start strobe into a reset pulse of RST_TICKS base ticks.
// Assumes: RST_TICKS >= 1; a new start restarts the pulse.
module wd_rst_pulse #(
    parameter int RST_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick_en,
    output logic pull_low
);
    localparam int W = $clog2(RST_TICKS + 1);

    logic [W-1:0] cnt_q;

    // Pulse is active while ticks remain.
    always_comb pull_low = (cnt_q != '0);

    // Remaining-ticks register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= W'(RST_TICKS);
        else if (tick_en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/wd_recovery_lock.sv
// Frequency-change watchdog: arms on software enable, counts after an
// accepted change, and on expiry sets status, locks into recovery and may
// pulse the open-drain reset. Also pulses reset on changes if enabled.
// Assumes: tick_en is the base time tick; the reset pad is external.
module wd_recovery_lock
    import wdr_pkg::*;
#(
    parameter int TIMER_W    = 5,
    parameter int SHORT_UNIT = 150,
    parameter int LONG_UNIT  = 2500,
    parameter int RST_TICKS  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               wd_arm,
    input  logic [TIMER_W-1:0] wd_count,
    input  logic               wd_long,
    input  logic               rst_on_expire_en,
    input  logic               rst_on_change_en,
    input  logic               freq_change_req,
    input  logic               stat_wr,
    input  logic               stat_wdata,
    output logic               freq_wr_grant,
    output logic               wd_status,
    output logic               wd_locked,
    output logic               recov_sel,
    output logic               rst_pull_low
);
    wd_state_e state_q;
    logic      running;
    logic      unit_tick;
    logic      expire;
    logic      pulse_start;

    // Requests are accepted unless the recovery lock is held.
    always_comb freq_wr_grant = freq_change_req && (state_q != WD_LOCK);

    always_comb running     = (state_q == WD_RUN);
    always_comb wd_locked   = (state_q == WD_LOCK);
    always_comb recov_sel   = (state_q == WD_LOCK);
    always_comb pulse_start = (expire && rst_on_expire_en)
                           || (freq_wr_grant && rst_on_change_en);

    wd_prescaler #(
        .SHORT_UNIT(SHORT_UNIT),
        .LONG_UNIT (LONG_UNIT)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!running || freq_wr_grant),
        .tick_en  (tick_en),
        .long_sel (wd_long),
        .unit_tick(unit_tick)
    );

    wd_downcount #(
        .TIMER_W(TIMER_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (!wd_arm || freq_wr_grant),
        .load_val(wd_count),
        .dec     (unit_tick),
        .expire  (expire)
    );

    wd_rst_pulse #(
        .RST_TICKS(RST_TICKS)
    ) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pulse_start),
        .tick_en (tick_en),
        .pull_low(rst_pull_low)
    );

    // Control state: idle until a change, run until expiry, hold the lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !wd_arm)
            state_q <= WD_IDLE;
        else begin
            case (state_q)
                WD_IDLE: if (freq_wr_grant) state_q <= WD_RUN;
                WD_RUN:  if (expire)        state_q <= WD_LOCK;
                WD_LOCK: state_q <= WD_LOCK;
                default: state_q <= WD_IDLE;
            endcase
        end
    end

    // Sticky time-out flag: expiry sets, a write of one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wd_status <= 1'b0;
        else if (expire)
            wd_status <= 1'b1;
        else if (stat_wr && stat_wdata)
            wd_status <= 1'b0;
    end
endmodule

// File: rtl/wdr_checker.sv
// Temporal checks on the watchdog ports; bound to the top module below.
// Assumes: synchronous active-low reset on rst_n.
module wdr_checker (
    input logic clk,
    input logic rst_n,
    input logic wd_arm,
    input logic rst_on_expire_en,
    input logic rst_on_change_en,
    input logic stat_wr,
    input logic stat_wdata,
    input logic freq_wr_grant,
    input logic wd_status,
    input logic wd_locked,
    input logic rst_pull_low
);
    assert_lock_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_locked) |-> wd_status);

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_locked && wd_arm) |=> wd_locked);

    assert_disarm_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_arm |=> !wd_locked);

    assert_expire_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wd_locked) && $past(rst_on_expire_en)) |-> rst_pull_low);

    assert_change_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr_grant && rst_on_change_en) |=> rst_pull_low);

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_status && !(stat_wr && stat_wdata)) |=> wd_status);
endmodule

bind wd_recovery_lock wdr_checker chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wd_arm          (wd_arm),
    .rst_on_expire_en(rst_on_expire_en),
    .rst_on_change_en(rst_on_change_en),
    .stat_wr         (stat_wr),
    .stat_wdata      (stat_wdata),
    .freq_wr_grant   (freq_wr_grant),
    .wd_status       (wd_status),
    .wd_locked       (wd_locked),
    .rst_pull_low    (rst_pull_low)
);

// File: tb/wd_recovery_lock_tb_top.sv
// Directed bench for the frequency-change watchdog.
module wd_recovery_lock_tb_top;
    localparam int TW = 5;
    localparam int SU = 3;
    localparam int LU = 5;
    localparam int RT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b1;
    logic          wd_arm = 1'b0;
    logic [TW-1:0] wd_count = '0;
    logic          wd_long = 1'b0;
    logic          rst_on_expire_en = 1'b0;
    logic          rst_on_change_en = 1'b0;
    logic          freq_change_req = 1'b0;
    logic          stat_wr = 1'b0;
    logic          stat_wdata = 1'b0;
    logic          freq_wr_grant, wd_status, wd_locked, recov_sel, rst_pull_low;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wd_recovery_lock #(
        .TIMER_W(TW), .SHORT_UNIT(SU), .LONG_UNIT(LU), .RST_TICKS(RT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_arm(wd_arm),
        .wd_count(wd_count), .wd_long(wd_long),
        .rst_on_expire_en(rst_on_expire_en), .rst_on_change_en(rst_on_change_en),
        .freq_change_req(freq_change_req), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .freq_wr_grant(freq_wr_grant), .wd_status(wd_status), .wd_locked(wd_locked),
        .recov_sel(recov_sel), .rst_pull_low(rst_pull_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Request a change across one edge; returns the grant seen before it.
    task automatic do_change(output logic g);
        @(negedge clk);
        freq_change_req = 1'b1;
        #1 g = freq_wr_grant;
        @(negedge clk);
        freq_change_req = 1'b0;
    endtask

    // Disarm, clear status, then arm with new fields.
    task automatic prep(input int cnt, input logic lng, input logic xen, input logic cen);
        @(negedge clk);
        wd_arm = 1'b0; stat_wr = 1'b1; stat_wdata = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = 1'b0;
        wd_count = TW'(cnt); wd_long = lng;
        rst_on_expire_en = xen; rst_on_change_en = cen;
        wd_arm = 1'b1;
    endtask

    // Called right after the accepting edge; checks the exact expiry edge.
    task automatic expect_expiry(input int ticks, input logic xen, input string req);
        edges(ticks - 1);
        chk({req, " status before expiry"}, wd_status, 0);
        edges(1);
        chk({req, " status at expiry"}, wd_status, 1);
        chk("R7 locked at expiry", wd_locked, 1);
        chk("R7 recov_sel at expiry", recov_sel, 1);
        chk("R9 reset pulse matches enable", rst_pull_low, xen);
        if (xen) begin
            edges(RT - 1);
            chk("R9 pulse still low", rst_pull_low, 1);
            edges(1);
            chk("R9 pulse released", rst_pull_low, 0);
        end
    endtask

    task automatic t_reset;
        chk("R1 status", wd_status, 0);
        chk("R1 locked", wd_locked, 0);
        chk("R1 recov_sel", recov_sel, 0);
        chk("R1 pull_low", rst_pull_low, 0);
    endtask

    task automatic t_armed_idle;
        prep(2, 1'b0, 1'b1, 1'b0);
        edges(60);
        chk("R2 no expiry without change", wd_status, 0);
        chk("R2 no lock without change", wd_locked, 0);
    endtask

    task automatic t_short;
        logic g;
        prep(4, 1'b0, 1'b0, 1'b0);
        do_change(g);
        chk("R3 grant", g, 1);
        expect_expiry(4 * SU, 1'b0, "R3");
    endtask

    task automatic t_status_and_lock;
        logic g;
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b0;
        @(negedge clk); stat_wr = 1'b0;
        chk("R6 write 0 keeps status", wd_status, 1);
        stat_wr = 1'b1; stat_wdata = 1'b1;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = 1'b0;
        chk("R6 write 1 clears status", wd_status, 0);
        chk("R7 lock survives status clear", wd_locked, 1);
        rst_on_change_en = 1'b1;
        do_change(g);
        chk("R7 locked request refused", g, 0);
        chk("R7 refused request gives no pulse", rst_pull_low, 0);
        edges(40);
        chk("R7 refused request starts no count", wd_status, 0);
        chk("R7 still locked", wd_locked, 1);
    endtask

    task automatic t_unlock_and_stop;
        logic g;
        @(negedge clk); wd_arm = 1'b0;
        @(negedge clk);
        chk("R8 unlock on disarm", wd_locked, 0);
        chk("R8 recov_sel cleared", recov_sel, 0);
        wd_arm = 1'b1; wd_count = TW'(4);
        do_change(g);
        chk("R8 grant after unlock", g, 1);
        chk("R10 change pulse low", rst_pull_low, 1);
        edges(RT - 1);
        chk("R10 change pulse held", rst_pull_low, 1);
        edges(1);
        chk("R10 change pulse released", rst_pull_low, 0);
        edges(4);
        @(negedge clk); wd_arm = 1'b0;
        @(negedge clk); wd_arm = 1'b1;
        edges(60);
        chk("R11 disarm mid-count prevents expiry", wd_status, 0);
    endtask

    task automatic t_long;
        logic g;
        prep(3, 1'b1, 1'b1, 1'b0);
        do_change(g);
        expect_expiry(3 * LU, 1'b1, "R4");
    endtask

    task automatic t_zero;
        logic g;
        prep(0, 1'b0, 1'b0, 1'b0);
        do_change(g);
        expect_expiry(32 * SU, 1'b0, "R5");
    endtask

    task automatic t_retrigger;
        logic g;
        prep(2, 1'b0, 1'b0, 1'b0);
        do_change(g);
        edges(3);
        do_change(g);
        chk("R12 retrigger granted", g, 1);
        expect_expiry(2 * SU, 1'b0, "R12");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        edges(4);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_armed_idle();
        t_short();
        t_status_and_lock();
        t_unlock_and_stop();
        t_long();
        t_zero();
        t_retrigger();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule